// File: doc/BRIEF.md
# Wall-Following Steering Controller

This block is the decision core of a small maze-walking robot that finds its way by keeping a wall on its right-hand side. Two touch feelers report contact: one on the left and one on the right, each 1 while pressed against a wall. Each clock the block picks the next steering state from the current state and the feelers. It issues three actuator commands: a forward step, a slight left turn and a slight right turn.

The machine is a Moore machine with four states in two state bits. The two wall-lost states of the larger form are merged, because they behave the same. The commands decode from the registered state alone, so they never glitch with the feelers and always follow them one clock later. An illegal state code is steered back to the wall-search state. The motor drivers, feeler debouncing and any map of the maze sit outside the block.

Top module: `wf_steer_ctrl`

## Requirements
- R1: While rst_ni is low, and after it rises until the first clock edge with sensors applied, the block is in the search state: fwd_o=1, turn_l_o=0, turn_r_o=0.
- R2: Commands per state as {fwd_o,turn_l_o,turn_r_o}: search 100, pivot 010, hugging 110, drifting 101. turn_l_o and turn_r_o are never 1 together.
- R3: In search, the block stays in search while both feelers are clear. If either feeler touches, the next state is pivot.
- R4: In pivot, the block stays in pivot while the left feeler touches. With only the right feeler touching, the next state is hugging. With both feelers clear, the next state is drifting.
- R5: In hugging, a touching left feeler leads to pivot. Right touching with left clear keeps hugging. Both clear leads to drifting.
- R6: In drifting, the left feeler is ignored. The right feeler touching leads to hugging, and the right feeler clear keeps drifting.
- R7: A change on the feelers changes no command before the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| feel_l_i | input | 1 | Left feeler, 1 when touching a wall |
| feel_r_i | input | 1 | Right feeler, 1 when touching a wall |
| fwd_o | output | 1 | Step forward |
| turn_l_o | output | 1 | Slight left turn |
| turn_r_o | output | 1 | Slight right turn |

## Verification
Each of the four states drives a different command pattern, so the state register can be read at the ports in every cycle. A wrong transition therefore shows up as a wrong command pattern exactly one clock after the feeler values that caused it. The bench walks one feeler pattern per cycle and checks the commands after every edge. Because of this, a bad next-state entry or a swapped output bit is caught on the first cycle it matters, and does not wait to surface as a later side effect.

// File: rtl/wf_steer_pkg.sv
package wf_steer_pkg;
  localparam int unsigned STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_SEARCH = 2'b00,
    ST_PIVOT  = 2'b01,
    ST_HUG    = 2'b10,
    ST_DRIFT  = 2'b11
  } steer_state_e;

  typedef struct packed {
    logic fwd;
    logic turn_l;
    logic turn_r;
  } steer_cmd_t;
endpackage

// File: rtl/wf_next_state.sv
module wf_next_state
  import wf_steer_pkg::*;
(
  input  steer_state_e state_i,
  input  logic         feel_l_i,
  input  logic         feel_r_i,
  output steer_state_e state_nxt_o
);
  always_comb begin
    unique case (state_i)
      ST_SEARCH: state_nxt_o = (feel_l_i || feel_r_i) ? ST_PIVOT : ST_SEARCH;
      ST_PIVOT: begin
        if (feel_l_i)      state_nxt_o = ST_PIVOT;
        else if (feel_r_i) state_nxt_o = ST_HUG;
        else               state_nxt_o = ST_DRIFT;
      end
      ST_HUG: begin
        if (feel_l_i)      state_nxt_o = ST_PIVOT;
        else if (feel_r_i) state_nxt_o = ST_HUG;
        else               state_nxt_o = ST_DRIFT;
      end
      ST_DRIFT:  state_nxt_o = feel_r_i ? ST_HUG : ST_DRIFT;  // left ignored
      default:   state_nxt_o = ST_SEARCH;
    endcase
  end
endmodule

// File: rtl/wf_act_decode.sv
module wf_act_decode
  import wf_steer_pkg::*;
(
  input  steer_state_e state_i,
  output steer_cmd_t   cmd_o
);
  always_comb begin
    cmd_o = '{fwd: 1'b1, turn_l: 1'b0, turn_r: 1'b0};
    case (state_i)
      ST_PIVOT: cmd_o = '{fwd: 1'b0, turn_l: 1'b1, turn_r: 1'b0};
      ST_HUG:   cmd_o = '{fwd: 1'b1, turn_l: 1'b1, turn_r: 1'b0};
      ST_DRIFT: cmd_o = '{fwd: 1'b1, turn_l: 1'b0, turn_r: 1'b1};
      default:  cmd_o = '{fwd: 1'b1, turn_l: 1'b0, turn_r: 1'b0};
    endcase
  end
endmodule

// File: rtl/wf_steer_ctrl.sv
module wf_steer_ctrl
  import wf_steer_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic feel_l_i,
  input  logic feel_r_i,
  output logic fwd_o,
  output logic turn_l_o,
  output logic turn_r_o
);
  steer_state_e state_q, state_d;
  steer_cmd_t   cmd;

  wf_next_state u_nxt (
    .state_i    (state_q),
    .feel_l_i   (feel_l_i),
    .feel_r_i   (feel_r_i),
    .state_nxt_o(state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_SEARCH;
    else         state_q <= state_d;
  end

  wf_act_decode u_dec (
    .state_i(state_q),
    .cmd_o  (cmd)
  );

  assign fwd_o    = cmd.fwd;
  assign turn_l_o = cmd.turn_l;
  assign turn_r_o = cmd.turn_r;

  AST_TURN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(turn_l_o && turn_r_o)); // R2
  AST_SEARCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEARCH && !feel_l_i && !feel_r_i) |=> (fwd_o && !turn_l_o && !turn_r_o)); // R3
  AST_SEARCH_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEARCH && (feel_l_i || feel_r_i)) |=> (!fwd_o && turn_l_o)); // R3
  AST_PIVOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PIVOT && feel_l_i) |=> (!fwd_o && turn_l_o && !turn_r_o)); // R4
  AST_HUG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HUG && !feel_l_i && !feel_r_i) |=> (fwd_o && turn_r_o)); // R5
  AST_DRIFT_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRIFT && feel_r_i) |=> (fwd_o && turn_l_o && !turn_r_o)); // R6
endmodule

// File: tb/wf_steer_ctrl_test.sv
`timescale 1ns/1ps
module wf_steer_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fl = 1'b0, fr = 1'b0;
  logic fwd, tl, tr;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  wf_steer_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .feel_l_i(fl), .feel_r_i(fr),
    .fwd_o(fwd), .turn_l_o(tl), .turn_r_o(tr)
  );

  // {left, right, exp fwd, exp tl, exp tr, req number}
  localparam int NV = 14;
  localparam logic [8:0] VEC [NV] = '{
    {2'b00, 3'b100, 4'd3},  // R3 search holds
    {2'b01, 3'b010, 4'd3},  // R3 right hit -> pivot
    {2'b11, 3'b010, 4'd4},  // R4 pivot holds
    {2'b10, 3'b010, 4'd4},  // R4 pivot holds on left
    {2'b01, 3'b110, 4'd4},  // R4 right only -> hug
    {2'b01, 3'b110, 4'd5},  // R5 hug holds
    {2'b00, 3'b101, 4'd5},  // R5 clear -> drift
    {2'b10, 3'b101, 4'd6},  // R6 left ignored
    {2'b00, 3'b101, 4'd6},  // R6 drift holds
    {2'b01, 3'b110, 4'd6},  // R6 right -> hug
    {2'b11, 3'b010, 4'd5},  // R5 left -> pivot
    {2'b00, 3'b101, 4'd4},  // R4 clear -> drift
    {2'b11, 3'b110, 4'd6},  // R6 right with left -> hug
    {2'b10, 3'b010, 4'd5}   // R5 left only -> pivot
  };

  task automatic check(input logic [2:0] exp, input int req);
    total++;
    if ({fwd, tl, tr} !== exp) begin
      bad++;
      $display("FAIL R%0d: got %b expected %b", req, {fwd, tl, tr}, exp);
    end
    if (tl && tr) begin
      bad++;
      $display("FAIL R2: both turns set, got %b", {fwd, tl, tr});
    end
  endtask

  initial begin
    #2000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1; check(3'b100, 1);  // R1 in reset
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1; check(3'b100, 1);  // R1 after release
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {fl, fr} = VEC[i][8:7];
      @(posedge clk); #1;
      check(VEC[i][6:4], int'(VEC[i][3:0]));  // R2 per-state map
    end
    // R7: sensor change before an edge leaves commands alone (in pivot)
    @(negedge clk); {fl, fr} = 2'b00;
    #1; check(3'b010, 7);
    @(posedge clk); #1; check(3'b101, 7);
    // R1: mid-run reset returns to search
    @(negedge clk); rst_n = 1'b0; {fl, fr} = 2'b01;
    #1; check(3'b100, 1);
    @(posedge clk); #1; check(3'b100, 1);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1; check(3'b010, 3);  // R3 left-or-right hit
    @(negedge clk); {fl, fr} = 2'b00;
    @(posedge clk); #1; check(3'b101, 4);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule